// File: doc/BRIEF.md
# Consumer Clock Source Mux-Divider

This block drives six consumer clock enables from a shared fast clock. Each consumer takes its input from one of seven single-cycle enable streams: one auxiliary PLL stream and six generator streams. It can also be switched off. The selected stream is then divided by a small factor. All six selectors are held in one 32-bit control register, with a 5-bit field for each consumer. Software writes the whole register and reads it back unchanged.

In each 5-bit field, the upper three bits hold the source code: zero means off, one picks the auxiliary stream, and two to seven pick generators zero to five. The lower two bits index a divide table. The table does not rise with the code, and a parameter chooses between two variants. To turn a consumer off, software clears its source bits and leaves its divide bits in place, so the consumer can later be switched back on with the same divide. Whenever a consumer's field changes, its pulse counter restarts, and the new setting counts from the next selected pulse.

Top module: `clk_src_mux_div`

## Requirements
- R1: While reset is held, and after its release until the first write, the register reads zero and every consumer output is low.
- R2: A write stores all 32 bits of `wr_data`, and `rd_data` shows that value from the next cycle. Without a write, `rd_data` does not change.
- R3: Consumer i is set by register bits [5i+4:5i]. A field for one consumer has no effect on any other consumer's output.
- R4: A source code of 0 (field bits [4:2] = 000) keeps that consumer's output low, whatever pulses arrive.
- R5: Source code 1 selects `aux_tick`, and source code k, for k from 2 to 7, selects `gen_tick[k-2]`. Pulses on streams that are not selected are ignored.
- R6: With `ALT_DIV`=0, divide code c (field bits [1:0]) divides by 1, 4, 1 and 2 for c = 0, 1, 2 and 3.
- R7: With `ALT_DIV`=1, divide code 2 divides by 3. The other codes keep the values given in R6.
- R8: A consumer with divide N raises its output for one cycle, in the cycle after every Nth selected input pulse, counting from a cleared counter.
- R9: A write that changes a consumer's field clears that consumer's counter. A selected pulse in the same cycle as that write is not counted. A write that leaves the field unchanged does not disturb the count.
- R10: Clearing only the source bits turns the output off and keeps the divide bits. Setting the source again restores the divide held in those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 32 | Value to store |
| rd_data | output | 32 | Current register contents |
| aux_tick | input | 1 | Auxiliary PLL enable stream |
| gen_tick | input | 6 | Generator enable streams 0..5 |
| cons_tick | output | 6 | Consumer enable outputs 0..5 |

## Verification
A counter left in the wrong state shows up at the ports as a shifted output pulse. The divide-by-4 check exposes it within at most four selected input pulses after a field change. A wrong source decode shows at once: either a pulse on an unselected stream produces output, or a selected stream stays silent. A wrong table entry changes the pulse count over a burst. The stimulus is therefore a set of bursts of known length, and the bench compares the number of output pulses with the expected quotient. Directed tests rewrite a field in the middle of a count to expose a stale counter.

// File: rtl/csmd_pkg.sv
package csmd_pkg;
  localparam int DCODE_W = 2;
  localparam int DIV_W   = 3;

  // divide factor for a 2-bit code; alt adds divide-by-3 at code 2
  function automatic logic [DIV_W-1:0] div_of(input logic [DCODE_W-1:0] code,
                                               input bit alt);
    logic [DIV_W-1:0] d;
    case (code)
      2'd0:    d = 3'd1;
      2'd1:    d = 3'd4;
      2'd2:    d = alt ? 3'd3 : 3'd1;
      default: d = 3'd2;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/csmd_csr.sv
module csmd_csr #(
  parameter int REG_W  = 32,
  parameter int N_CONS = 6,
  parameter int FW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  csr_q,
  output logic [N_CONS-1:0] chg
);
  logic [REG_W-1:0] csr_d;

  always_comb begin
    csr_d = csr_q;
    if (wr_en) csr_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csr_q <= '0;
    else        csr_q <= csr_d;
  end

  for (genvar i = 0; i < N_CONS; i++) begin : g_chg
    assign chg[i] = wr_en && (wr_data[i*FW +: FW] != csr_q[i*FW +: FW]);
  end
endmodule

// File: rtl/csmd_slice.sv
module csmd_slice
  import csmd_pkg::*;
#(
  parameter int N_GEN   = 6,
  parameter int SEL_W   = 3,
  parameter bit ALT_DIV = 1'b0,
  localparam int FW     = SEL_W + DCODE_W,
  localparam int N_SRC  = N_GEN + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FW-1:0]    field,
  input  logic             field_chg,
  input  logic             aux_tick,
  input  logic [N_GEN-1:0] gen_tick,
  output logic             tick_o
);
  logic [SEL_W-1:0]   sel;
  logic [DCODE_W-1:0] dcode;
  logic [N_SRC-1:0]   srcs;
  logic               src_tick;
  logic [DIV_W-1:0]   lim;
  logic [DCODE_W-1:0] cnt_q, cnt_d;
  logic               out_d;

  assign sel   = field[FW-1:DCODE_W];
  assign dcode = field[DCODE_W-1:0];
  // index 0 is the off state, 1 the aux stream, 2.. the generators
  assign srcs  = {gen_tick, aux_tick, 1'b0};

  always_comb begin
    src_tick = 1'b0;
    for (int k = 0; k < N_SRC; k++)
      if (sel == SEL_W'(k)) src_tick = srcs[k];
    lim = div_of(dcode, ALT_DIV) - 3'd1;
  end

  always_comb begin
    cnt_d = cnt_q;
    out_d = 1'b0;
    if (field_chg) begin
      cnt_d = '0;
    end else if (src_tick) begin
      if ({1'b0, cnt_q} >= lim) begin
        cnt_d = '0;
        out_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_o <= out_d;
    end
  end
endmodule

// File: rtl/clk_src_mux_div.sv
module clk_src_mux_div
  import csmd_pkg::*;
#(
  parameter int N_CONS  = 6,
  parameter int N_GEN   = 6,
  parameter int REG_W   = 32,
  parameter bit ALT_DIV = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              aux_tick,
  input  logic [N_GEN-1:0]  gen_tick,
  output logic [N_CONS-1:0] cons_tick
);
  localparam int SEL_W = $clog2(N_GEN + 2);
  localparam int FW    = SEL_W + DCODE_W;

  logic              rst_s1, rst_s2;
  logic [REG_W-1:0]  csr;
  logic [N_CONS-1:0] chg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  csmd_csr #(.REG_W(REG_W), .N_CONS(N_CONS), .FW(FW)) u_csr (
    .clk     (clk),
    .rst_n   (rst_s2),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .csr_q   (csr),
    .chg     (chg)
  );

  assign rd_data = csr;

  for (genvar i = 0; i < N_CONS; i++) begin : g_cons
    csmd_slice #(.N_GEN(N_GEN), .SEL_W(SEL_W), .ALT_DIV(ALT_DIV)) u_slice (
      .clk       (clk),
      .rst_n     (rst_s2),
      .field     (csr[i*FW +: FW]),
      .field_chg (chg[i]),
      .aux_tick  (aux_tick),
      .gen_tick  (gen_tick),
      .tick_o    (cons_tick[i])
    );
  end
endmodule

// File: rtl/csmd_chk.sv
module csmd_chk #(
  parameter int N_CONS = 6,
  parameter int N_GEN  = 6,
  parameter int REG_W  = 32,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_data,
  input logic [REG_W-1:0]  rd_data,
  input logic              aux_tick,
  input logic [N_GEN-1:0]  gen_tick,
  input logic [N_CONS-1:0] cons_tick
);
  localparam int FW = SEL_W + 2;

  // R2: written value appears on the next cycle
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  // R2: register holds without a write
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  // R8: no input pulse anywhere means no output pulse next cycle
  a_r8_no_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!aux_tick && gen_tick == '0) |=> cons_tick == '0);

  for (genvar i = 0; i < N_CONS; i++) begin : g_c
    // R4: an off consumer produces nothing
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[i*FW+2 +: SEL_W] == '0) |=> !cons_tick[i]);

    // R9: a changing write swallows that cycle's pulse
    a_r9_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[i*FW +: FW] != rd_data[i*FW +: FW]) |=> !cons_tick[i]);
  end
endmodule

bind clk_src_mux_div csmd_chk #(
  .N_CONS(N_CONS), .N_GEN(N_GEN), .REG_W(REG_W), .SEL_W(SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_s2),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .aux_tick  (aux_tick),
  .gen_tick  (gen_tick),
  .cons_tick (cons_tick)
);

// File: tb/tb_clk_src_mux_div.sv
module tb_clk_src_mux_div;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {sel[2:0], code[1:0], src[2:0] (0 aux, k gen k-1), npulses[7:0], expect[7:0]}
  localparam logic [23:0] VEC [NV] = '{
    {3'd1, 2'd0, 3'd0, 8'd5, 8'd5},  // R5 R6 R8 aux div1
    {3'd1, 2'd1, 3'd0, 8'd9, 8'd2},  // R6 R8 div4
    {3'd1, 2'd3, 3'd0, 8'd7, 8'd3},  // R6 R8 div2
    {3'd1, 2'd2, 3'd0, 8'd4, 8'd4},  // R6 code2 = div1 in default table
    {3'd2, 2'd3, 3'd1, 8'd6, 8'd3},  // R5 gen0
    {3'd7, 2'd1, 3'd6, 8'd8, 8'd2},  // R5 gen5
    {3'd3, 2'd0, 3'd0, 8'd5, 8'd0},  // R5 unselected aux ignored
    {3'd0, 2'd0, 3'd0, 8'd5, 8'd0},  // R4 off
    {3'd0, 2'd2, 3'd1, 8'd3, 8'd0},  // R4 off
    {3'd4, 2'd0, 3'd3, 8'd3, 8'd3},  // R5 gen2
    {3'd6, 2'd3, 3'd5, 8'd5, 8'd2}   // R5 gen4
  };

  logic        clk, rst_n, wr_en, aux_tick;
  logic [31:0] wr_data, rd_a, rd_b;
  logic [5:0]  gen_tick, cons_a, cons_b;
  int checks = 0, fails = 0;
  int cnt_a, cnt_b, other_a;
  bit done = 0;

  clk_src_mux_div dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_a),
    .aux_tick(aux_tick), .gen_tick(gen_tick), .cons_tick(cons_a));

  clk_src_mux_div #(.ALT_DIV(1'b1)) dut3 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b),
    .aux_tick(aux_tick), .gen_tick(gen_tick), .cons_tick(cons_b));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sample(input int ci);
    cnt_a += int'(cons_a[ci]);
    cnt_b += int'(cons_b[ci]);
    for (int k = 0; k < 6; k++) if (k != ci) other_a += int'(cons_a[k]);
  endtask

  task automatic clear_counts();
    cnt_a = 0; cnt_b = 0; other_a = 0;
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulses(input int src, input int n, input int ci);
    for (int p = 0; p < n; p++) begin
      @(negedge clk);
      if (src == 0) aux_tick = 1'b1; else gen_tick[src-1] = 1'b1;
      @(negedge clk);
      aux_tick = 1'b0; gen_tick = '0;
      sample(ci);
      @(negedge clk);
      sample(ci);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; wr_en = 1'b0; wr_data = '0; aux_tick = 1'b0; gen_tick = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset rd_data", int'(rd_a), 0);
    check("R1 reset outputs", int'(cons_a), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release rd_data", int'(rd_a), 0);
    check("R1 after release outputs", int'(cons_a), 0);

    // vector table on consumer 0
    for (int v = 0; v < NV; v++) begin
      wr(32'h0);
      wr({27'd0, VEC[v][23:21], VEC[v][20:19]});
      clear_counts();
      pulses(int'(VEC[v][18:16]), int'(VEC[v][15:8]), 0);
      check($sformatf("R5/R6/R8/R4 vector %0d", v), cnt_a, int'(VEC[v][7:0]));
    end

    // R3: consumer 5 field at bits 29:25, aux div4
    wr(32'h0);
    wr(32'd5 << 25);
    @(negedge clk);
    check("R2 readback", int'(rd_a), int'(32'd5 << 25));
    clear_counts();
    pulses(0, 8, 5);
    check("R3 consumer5 count", cnt_a, 2);
    check("R3 other consumers quiet", other_a, 0);

    // R2: full 32 bits stored
    wr(32'hC000_0000);
    check("R2 top bits stored", int'(rd_a), int'(32'hC000_0000));

    // R7: code 2 with aux on consumer 0 - alt divides by 3, default by 1
    wr(32'h0);
    wr(32'h6);
    clear_counts();
    pulses(0, 6, 0);
    check("R7 alt table div3", cnt_b, 2);
    check("R6 default table code2", cnt_a, 6);

    // R9: change mid-count clears counter
    wr(32'h0);
    wr(32'h5);                 // aux div4
    clear_counts();
    pulses(0, 3, 0);
    wr(32'h7);                 // aux div2
    pulses(0, 1, 0);
    check("R9 cleared after change, first pulse", cnt_a, 0);
    pulses(0, 1, 0);
    check("R9 cleared after change, second pulse", cnt_a, 1);

    // R9: same-value rewrite keeps count
    wr(32'h0);
    wr(32'h5);
    clear_counts();
    pulses(0, 2, 0);
    wr(32'h5);
    pulses(0, 2, 0);
    check("R9 same-value rewrite keeps count", cnt_a, 1);

    // R9: pulse in the changing-write cycle is not counted
    wr(32'h0);
    clear_counts();
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h7; aux_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; aux_tick = 1'b0; sample(0);
    pulses(0, 1, 0);
    check("R9 write-cycle pulse dropped", cnt_a, 0);
    pulses(0, 1, 0);
    check("R9 count resumes", cnt_a, 1);

    // R10: disable keeps divide bits, re-enable restores divide
    wr(32'h0);
    wr(32'h5);
    wr(32'h1);
    check("R10 divide bits kept", int'(rd_a), 1);
    clear_counts();
    pulses(0, 4, 0);
    check("R10 disabled quiet", cnt_a, 0);
    wr(rd_a | 32'h4);
    pulses(0, 8, 0);
    check("R10 re-enabled div4", cnt_a, 2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule